// File: doc/BRIEF.md
# Programmable Frequency Sweep Sequencer

This block runs a direct digital synthesis phase accumulator through a programmed list of excitation frequencies. Software loads a start word, a step word, a number of steps after the start point and a settling length. It then drives the sweep with short commands: begin at the start frequency, launch the sweep, step to the next frequency, measure the same frequency again, go to standby or power down. A separate reset command stops the sweep and leaves the loaded settings in place.

At each point the block waits a programmed number of excitation cycles so the analog path can settle. It then pulses a start strobe to a DFT engine and waits for that engine's done strobe. The phase value drives an external sine table. Two flags report that a measurement for the current point is ready and that the last point of the sweep has been measured.

Top module: `sweep_seq`

## Requirements
- R1: After the synchronous reset input, `mode` is 0 (off), and `phase_o`, `freq_o`, `dft_start`, `data_valid` and `sweep_done` are all 0.
- R2: The begin command (code 4'b0001) loads `freq_o` with the start word, restarts `phase_o` at 0, makes `mode` 2 (output live) and clears both flags. The launch command (4'b0010) is ignored unless it follows a begin command with no sweep running.
- R3: While `mode` is 2, `phase_o` advances by `freq_o` modulo 2^27 once every DIV clocks and is otherwise stable. Outside mode 2 it is 0.
- R4: After launch, step or again, `dft_start` pulses once a number of excitation cycles (accumulator wraps) equal to the settle count times the scale has passed. Scale code 2'b01 gives x2, 2'b11 gives x4, and 2'b00 or 2'b10 gives x1. A count of 0 pulses on the clock after the command.
- R5: `dft_start` lasts one clock. `dft_done` during a measurement sets `data_valid`. `data_valid` is 0 while a new point settles.
- R6: The step command (4'b0011) after a measured point adds the step word to `freq_o`. The again command (4'b0100) re-measures with `freq_o` unchanged.
- R7: `sweep_done` is set when the point just measured has index at least the step count, with the start point as index 0. A sweep therefore covers count+1 frequencies. After that, step commands are ignored.
- R8: A command with `cmd_reset` high sets `mode` to 1 (standby) and clears both flags. It keeps the loaded start, step, count and settle settings. Launch is then ignored until a new begin command.
- R9: Code 4'b1010 sets `mode` to 0 and code 4'b1011 sets `mode` to 1. Both stop the accumulator and hold `phase_o` at 0.
- R10: Command codes other than the six listed are ignored. `dft_done` outside a measurement is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Latch the five settings below |
| cfg_start_word | input | 27 | Start frequency word |
| cfg_step_word | input | 27 | Frequency step word |
| cfg_steps | input | 9 | Steps after the start point |
| cfg_settle | input | 9 | Settling length in excitation cycles |
| cfg_scale | input | 2 | Settling multiplier code |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code |
| cmd_reset | input | 1 | Reset command, overrides the code |
| dft_done | input | 1 | DFT engine finished the point |
| phase_o | output | 27 | Phase accumulator value |
| freq_o | output | 27 | Current frequency word |
| dft_start | output | 1 | Start a DFT measurement |
| data_valid | output | 1 | Measurement ready for this point |
| sweep_done | output | 1 | Last point measured |
| mode | output | 2 | 0 off, 1 standby, 2 output live |

## Verification
A wrong sweep state shows up quickly at the ports. It changes `mode`, lets `freq_o` move when it should not, or stops `dft_start` from arriving after the expected number of accumulator wraps. Each of these appears within one clock of the command, or within one excitation cycle of the expected strobe. A wrong settle count or scale decode moves the `dft_start` pulse by whole excitation cycles, which is many clocks. Comparing against a cycle-exact model every clock therefore catches any drift in the phase value, the strobe timing and the flags at the first cycle where they differ.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_STBY,
        ST_BEGIN,
        ST_SETTLE,
        ST_MEAS,
        ST_HOLD
    } sweep_state_t;

    localparam logic [3:0] CMD_BEGIN  = 4'b0001;
    localparam logic [3:0] CMD_LAUNCH = 4'b0010;
    localparam logic [3:0] CMD_STEP   = 4'b0011;
    localparam logic [3:0] CMD_AGAIN  = 4'b0100;
    localparam logic [3:0] CMD_SLEEP  = 4'b1010;
    localparam logic [3:0] CMD_IDLE   = 4'b1011;

    localparam logic [1:0] MODE_OFF  = 2'd0;
    localparam logic [1:0] MODE_STBY = 2'd1;
    localparam logic [1:0] MODE_LIVE = 2'd2;

    function automatic logic [1:0] scale_shift(input logic [1:0] code);
        case (code)
            2'b01:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] state_mode(input sweep_state_t s);
        case (s)
            ST_OFF:  return MODE_OFF;
            ST_STBY: return MODE_STBY;
            default: return MODE_LIVE;
        endcase
    endfunction

endpackage

// File: rtl/sweep_prescale.sv
module sweep_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_count
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || cnt == LAST) cnt <= '0;
                else                    cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/sweep_phase.sv
module sweep_phase #(
    parameter int W = 27
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] freq,
    output logic [W-1:0] phase,
    output logic         wrap
);
    logic [W:0] sum;
    assign sum  = {1'b0, phase} + {1'b0, freq};
    assign wrap = run && tick && !clr && sum[W];

    always_ff @(posedge clk) begin
        if (rst || clr)       phase <= '0;
        else if (run && tick) phase <= sum[W-1:0];
    end
endmodule

// File: rtl/sweep_settle.sv
module sweep_settle #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          wrap,
    output logic          expired
);
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)                        left <= '0;
        else if (load)                  left <= load_val;
        else if (wrap && left != '0)    left <= left - 1'b1;
    end

    assign expired = (left == '0);
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
    import sweep_pkg::*;
#(
    parameter int FREQ_W = 27,
    parameter int CNT_W  = 9,
    parameter int SET_W  = 9,
    parameter int DIV    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [FREQ_W-1:0] cfg_start_word,
    input  logic [FREQ_W-1:0] cfg_step_word,
    input  logic [CNT_W-1:0]  cfg_steps,
    input  logic [SET_W-1:0]  cfg_settle,
    input  logic [1:0]        cfg_scale,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic              cmd_reset,
    input  logic              dft_done,
    output logic [FREQ_W-1:0] phase_o,
    output logic [FREQ_W-1:0] freq_o,
    output logic              dft_start,
    output logic              data_valid,
    output logic              sweep_done,
    output logic [1:0]        mode
);
    localparam int LW = SET_W + 2;

    logic [FREQ_W-1:0] start_r, step_r, freq_r;
    logic [CNT_W-1:0]  steps_r, point_r;
    logic [SET_W-1:0]  settle_r;
    logic [1:0]        scale_r;
    sweep_state_t      state;
    logic              valid_r, done_r, start_r_q;

    logic tick, wrap, expired, run, phase_clr, settle_load;
    logic [LW-1:0] load_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_r  <= '0;
            step_r   <= '0;
            steps_r  <= '0;
            settle_r <= '0;
            scale_r  <= '0;
        end else if (cfg_load) begin
            start_r  <= cfg_start_word;
            step_r   <= cfg_step_word;
            steps_r  <= cfg_steps;
            settle_r <= cfg_settle;
            scale_r  <= cfg_scale;
        end
    end

    logic plain, do_rst, do_begin, do_sleep, do_idle, do_launch, do_step, do_again;
    logic any_cmd, meas_go, meas_end;

    always_comb begin
        plain     = cmd_valid && !cmd_reset;
        do_rst    = cmd_valid && cmd_reset;
        do_begin  = plain && cmd_code == CMD_BEGIN;
        do_sleep  = plain && cmd_code == CMD_SLEEP;
        do_idle   = plain && cmd_code == CMD_IDLE;
        do_launch = plain && cmd_code == CMD_LAUNCH && state == ST_BEGIN;
        do_step   = plain && cmd_code == CMD_STEP && state == ST_HOLD && !done_r;
        do_again  = plain && cmd_code == CMD_AGAIN && state == ST_HOLD;
        any_cmd   = do_rst || do_begin || do_sleep || do_idle
                    || do_launch || do_step || do_again;
        settle_load = do_launch || do_step || do_again;
        phase_clr   = do_rst || do_begin || do_sleep || do_idle;
        run         = state_mode(state) == MODE_LIVE;
        meas_go     = state == ST_SETTLE && expired && !any_cmd;
        meas_end    = state == ST_MEAS && dft_done && !any_cmd;
        load_val    = LW'({2'b00, settle_r}) << scale_shift(scale_r);
    end

    sweep_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    sweep_phase #(.W(FREQ_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (phase_clr),
        .run   (run),
        .tick  (tick),
        .freq  (freq_r),
        .phase (phase_o),
        .wrap  (wrap)
    );

    sweep_settle #(.CW(LW)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .load     (settle_load),
        .load_val (load_val),
        .wrap     (wrap),
        .expired  (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_OFF;
            freq_r    <= '0;
            point_r   <= '0;
            valid_r   <= 1'b0;
            done_r    <= 1'b0;
            start_r_q <= 1'b0;
        end else begin
            start_r_q <= meas_go;
            if (do_rst) begin
                state   <= ST_STBY;
                valid_r <= 1'b0;
                done_r  <= 1'b0;
            end else if (do_begin) begin
                state   <= ST_BEGIN;
                freq_r  <= start_r;
                point_r <= '0;
                valid_r <= 1'b0;
                done_r  <= 1'b0;
            end else if (do_sleep) begin
                state <= ST_OFF;
            end else if (do_idle) begin
                state <= ST_STBY;
            end else if (settle_load) begin
                state   <= ST_SETTLE;
                valid_r <= 1'b0;
                if (do_step) begin
                    freq_r  <= freq_r + step_r;
                    point_r <= point_r + 1'b1;
                end
            end else if (meas_go) begin
                state <= ST_MEAS;
            end else if (meas_end) begin
                state   <= ST_HOLD;
                valid_r <= 1'b1;
                done_r  <= (point_r >= steps_r);
            end
        end
    end

    assign freq_o     = freq_r;
    assign dft_start  = start_r_q;
    assign data_valid = valid_r;
    assign sweep_done = done_r;
    assign mode       = state_mode(state);
endmodule

// File: rtl/sweep_seq_chk.sv
module sweep_seq_chk #(
    parameter int FW = 27
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          phase_clr,
    input logic [1:0]    mode,
    input logic [FW-1:0] phase_o,
    input logic [FW-1:0] freq_o,
    input logic          dft_start,
    input logic          data_valid,
    input logic          sweep_done
);
    assert_strobe_width_R5: assert property (@(posedge clk) disable iff (rst)
        dft_start |=> !dft_start);

    assert_fresh_point_R5: assert property (@(posedge clk) disable iff (rst)
        dft_start |-> !data_valid);

    assert_idle_phase_R9: assert property (@(posedge clk) disable iff (rst)
        mode != 2'd2 |-> phase_o == '0);

    assert_phase_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && $past(mode) == 2'd2 && !$past(tick) && !$past(phase_clr))
        |-> $stable(phase_o));

    assert_final_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        (sweep_done && $past(sweep_done)) |-> $stable(freq_o));

    assert_mode_legal_R9: assert property (@(posedge clk) disable iff (rst)
        mode != 2'd3);
endmodule

bind sweep_seq sweep_seq_chk #(.FW(FREQ_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .phase_clr  (phase_clr),
    .mode       (mode),
    .phase_o    (phase_o),
    .freq_o     (freq_o),
    .dft_start  (dft_start),
    .data_valid (data_valid),
    .sweep_done (sweep_done)
);

// File: tb/sweep_seq_test.sv
module sweep_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [26:0] cfg_start_word = '0, cfg_step_word = '0;
    logic [8:0]  cfg_steps = '0, cfg_settle = '0;
    logic [1:0]  cfg_scale = '0;
    logic        cmd_valid = 1'b0, cmd_reset = 1'b0, dft_done = 1'b0;
    logic [3:0]  cmd_code = '0;
    logic [26:0] phase_o, freq_o;
    logic        dft_start, data_valid, sweep_done;
    logic [1:0]  mode;

    always #5 clk = ~clk;

    sweep_seq uut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load),
        .cfg_start_word(cfg_start_word), .cfg_step_word(cfg_step_word),
        .cfg_steps(cfg_steps), .cfg_settle(cfg_settle), .cfg_scale(cfg_scale),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_reset(cmd_reset),
        .dft_done(dft_done), .phase_o(phase_o), .freq_o(freq_o),
        .dft_start(dft_start), .data_valid(data_valid),
        .sweep_done(sweep_done), .mode(mode)
    );

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // behavioural reference: states 0 off,1 standby,2 begun,3 settling,4 measuring,5 holding
    longint m_phase, m_freq, m_start, m_step;
    int m_pre, m_state, m_cnt, m_point, m_steps, m_settle, m_mul;
    bit m_valid, m_done, m_strobe;

    function automatic int mode_of(input int s);
        return (s == 0) ? 0 : (s == 1) ? 1 : 2;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_phase = 0; m_freq = 0; m_start = 0; m_step = 0;
            m_pre = 0; m_state = 0; m_cnt = 0; m_point = 0;
            m_steps = 0; m_settle = 0; m_mul = 1;
            m_valid = 0; m_done = 0; m_strobe = 0;
        end else begin
            automatic bit tk = (m_pre == 15);
            automatic bit live = (m_state >= 2);
            automatic bit pl = cmd_valid && !cmd_reset;
            automatic bit c_rst = cmd_valid && cmd_reset;
            automatic bit c_beg = pl && cmd_code == 4'b0001;
            automatic bit c_slp = pl && cmd_code == 4'b1010;
            automatic bit c_idl = pl && cmd_code == 4'b1011;
            automatic bit c_lau = pl && cmd_code == 4'b0010 && m_state == 2;
            automatic bit c_stp = pl && cmd_code == 4'b0011 && m_state == 5 && !m_done;
            automatic bit c_agn = pl && cmd_code == 4'b0100 && m_state == 5;
            automatic bit any = c_rst || c_beg || c_slp || c_idl || c_lau || c_stp || c_agn;
            automatic bit clr = c_rst || c_beg || c_slp || c_idl;
            automatic longint sum = m_phase + m_freq;
            automatic bit carry = live && tk && !clr && (sum >= (64'd1 << 27));
            automatic int old_state = m_state;
            automatic int old_cnt = m_cnt;
            m_pre = (m_pre + 1) % 16;
            m_strobe = (old_state == 3 && old_cnt == 0 && !any);
            if (clr) m_phase = 0;
            else if (live && tk) m_phase = sum % (64'd1 << 27);
            if (c_lau || c_stp || c_agn) m_cnt = m_settle * m_mul;
            else if (old_state == 3 && carry && m_cnt > 0) m_cnt--;
            if (c_rst) begin m_state = 1; m_valid = 0; m_done = 0; end
            else if (c_beg) begin
                m_state = 2; m_freq = m_start; m_point = 0; m_valid = 0; m_done = 0;
            end
            else if (c_slp) m_state = 0;
            else if (c_idl) m_state = 1;
            else if (c_lau || c_stp || c_agn) begin
                m_state = 3; m_valid = 0;
                if (c_stp) begin
                    m_freq = (m_freq + m_step) % (64'd1 << 27);
                    m_point++;
                end
            end
            else if (old_state == 3 && old_cnt == 0) m_state = 4;
            else if (old_state == 4 && dft_done) begin
                m_state = 5; m_valid = 1; m_done = (m_point >= m_steps);
            end
            if (cfg_load) begin
                m_start = cfg_start_word; m_step = cfg_step_word;
                m_steps = cfg_steps; m_settle = cfg_settle;
                m_mul = (cfg_scale == 2'b01) ? 2 : (cfg_scale == 2'b11) ? 4 : 1;
            end
        end
    end

    // every-clock comparison against the reference
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(phase_o == m_phase[26:0], "R3 phase", phase_o, m_phase);
            check(freq_o == m_freq[26:0], "R6 freq", freq_o, m_freq);
            check(dft_start == m_strobe, "R4 dft_start timing", dft_start, m_strobe);
            check(data_valid == m_valid, "R5 data_valid", data_valid, m_valid);
            check(sweep_done == m_done, "R7 sweep_done", sweep_done, m_done);
            check(mode == 2'(mode_of(m_state)), "R9 mode", mode, mode_of(m_state));
        end
    end

    task automatic send(input logic [3:0] c, input logic r);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c; cmd_reset = r;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_reset = 1'b0; cmd_code = '0;
    endtask

    task automatic load(input logic [26:0] s, input logic [26:0] st, input logic [8:0] n,
                        input logic [8:0] sl, input logic [1:0] sc);
        @(negedge clk);
        cfg_start_word = s; cfg_step_word = st; cfg_steps = n;
        cfg_settle = sl; cfg_scale = sc; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic measure(input string tag);
        int waited = 0;
        while (!dft_start && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        check(dft_start == 1'b1, tag, dft_start, 1);
        repeat (4) @(negedge clk);
        dft_done = 1'b1;
        @(negedge clk);
        dft_done = 1'b0;
        check(data_valid == 1'b1, "R5 valid after done", data_valid, 1);
    endtask

    initial begin
        while (cycles < 150000 && !finished) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        check(mode == 2'd0, "R1 mode", mode, 0);
        check(phase_o == 0 && freq_o == 0, "R1 phase/freq", phase_o, 0);
        check(!dft_start && !data_valid && !sweep_done, "R1 flags",
              {dft_start, data_valid, sweep_done}, 0);

        load(27'h200_0000, 27'h100_0000, 9'd2, 9'd2, 2'b01);
        send(4'b0010, 1'b0);
        check(mode == 2'd0, "R2 launch before begin ignored", mode, 0);
        send(4'b1011, 1'b0);
        check(mode == 2'd1, "R9 standby code", mode, 1);
        send(4'b0111, 1'b0);
        check(mode == 2'd1, "R10 unknown code ignored", mode, 1);
        send(4'b0001, 1'b0);
        check(mode == 2'd2 && freq_o == 27'h200_0000, "R2 begin loads start", freq_o, 27'h200_0000);
        // R10 dft_done outside a measurement
        dft_done = 1'b1; @(negedge clk); dft_done = 1'b0; @(negedge clk);
        check(data_valid == 1'b0, "R10 stray done ignored", data_valid, 0);
        repeat (40) @(negedge clk);
        send(4'b0010, 1'b0);
        measure("R4 first point strobe");
        send(4'b0011, 1'b0);
        check(freq_o == 27'h300_0000, "R6 step adds word", freq_o, 27'h300_0000);
        check(data_valid == 1'b0, "R5 valid cleared on new point", data_valid, 0);
        measure("R4 second point strobe");
        send(4'b0100, 1'b0);
        check(freq_o == 27'h300_0000, "R6 again keeps freq", freq_o, 27'h300_0000);
        measure("R4 repeat strobe");
        check(sweep_done == 1'b0, "R7 not yet done", sweep_done, 0);
        send(4'b0011, 1'b0);
        measure("R4 last point strobe");
        check(sweep_done == 1'b1, "R7 done after count+1 points", sweep_done, 1);
        send(4'b0011, 1'b0);
        check(freq_o == 27'h400_0000 && mode == 2'd2, "R7 step ignored when done", freq_o, 27'h400_0000);

        send(4'b0000, 1'b1);
        check(mode == 2'd1 && !data_valid && !sweep_done, "R8 reset to standby", mode, 1);
        send(4'b0010, 1'b0);
        check(mode == 2'd1, "R8 launch ignored after reset", mode, 1);
        send(4'b0001, 1'b0);
        check(freq_o == 27'h200_0000, "R8 settings kept", freq_o, 27'h200_0000);

        load(27'h100_0000, 27'h080_0000, 9'd0, 9'd0, 2'b11);
        send(4'b0001, 1'b0);
        send(4'b0010, 1'b0);
        @(negedge clk);
        check(dft_start == 1'b1, "R4 zero settle strobes next clock", dft_start, 1);
        repeat (3) @(negedge clk);
        dft_done = 1'b1; @(negedge clk); dft_done = 1'b0;
        check(sweep_done == 1'b1, "R7 single point sweep", sweep_done, 1);

        load(27'h200_0000, 27'h080_0000, 9'd1, 9'd1, 2'b11);
        send(4'b0001, 1'b0);
        send(4'b0010, 1'b0);
        measure("R4 x4 scale strobe");
        load(27'h200_0000, 27'h080_0000, 9'd1, 9'd3, 2'b10);
        send(4'b0100, 1'b0);
        measure("R4 reserved scale acts as x1");

        send(4'b1010, 1'b0);
        check(mode == 2'd0 && phase_o == 0, "R9 power down", phase_o, 0);
        repeat (40) @(negedge clk);
        check(phase_o == 0, "R3 phase held outside live", phase_o, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule